// File: doc/BRIEF.md
# Reuse-Hinted Replacement Tag Controller

This block holds the tag side of a small set-associative cache and decides which way is replaced on a miss. Each request carries a line address and a one-bit reuse hint. A set hint marks data the program does not expect to touch again. Every line keeps a tag, a valid flag, a discard flag and a per-way age counter. The block answers each request with hit or miss and the way involved. On a miss it asks a backing memory for the line through a valid/ready handshake. When the memory answers, the block installs the new tag in the chosen way.

A miss first fills an empty way if the set has one. Otherwise the victim is a line whose discard flag is set. If several lines have the flag, the oldest of them goes. The least recently used line is evicted only when no line in the set has the flag. A hit copies the request's hint into the line's discard flag and makes the line the youngest. A fill does the same for the new line.

The control is a three-state machine. ST_IDLE accepts a request and moves to ST_LOOKUP. ST_LOOKUP compares tags. On a hit it responds and returns to ST_IDLE. On a miss it latches the victim and moves to ST_FILL. ST_FILL holds the fill request until the memory asserts ready. It then installs the line, responds, and returns to ST_IDLE. Requests are only accepted in ST_IDLE.

Top module: `evict_hint_cache`

## Requirements
- R1: After reset, and after any later reset, every line is invalid and the per-way ages are reset to way w holding age w. `req_ready` is 1, and `resp_valid` and `fill_valid` are 0, until the first request arrives.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. If its tag matches a valid line in the set given by the low address bits, `resp_valid` and `resp_hit` are 1 in the very next cycle, and `resp_way` gives the matching way.
- R3: On a miss, `fill_valid` rises two cycles after acceptance with `fill_addr` equal to the request's line address. Both are held until `fill_ready` is 1. In that same cycle `resp_valid` is 1, `resp_hit` is 0 and `resp_way` is the filled way.
- R4: When the set has an invalid way, the miss fills the lowest-numbered invalid way, even if valid lines with the discard flag set exist.
- R5: When all ways are valid and one or more have the discard flag set, the victim is the flagged way with the largest age. This applies even when an unflagged way is older.
- R6: When all ways are valid and none is flagged, the victim is the way with the largest age, that is, the least recently used way.
- R7: A hit overwrites the line's discard flag with the request's hint (1 sets it, 0 clears it). The line takes age 0, and every way that was younger than it ages by one.
- R8: A fill sets the new line's discard flag to the hint of the missing request and gives it age 0 under the same ageing rule.
- R9: Tags, flags and ages are kept per set. Traffic to one set leaves the hit/miss outcome and victim choice of every other set unchanged.
- R10: `req_ready` is 0 from the cycle after acceptance until the cycle after the response, so a second request is never taken while one is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_addr | input | ADDR_W | Line address; low $clog2(SETS) bits select the set, the rest is the tag |
| req_hint | input | 1 | Reuse hint: 1 = not expected to be reused |
| resp_valid | output | 1 | Response present for one cycle |
| resp_hit | output | 1 | 1 = hit, 0 = miss that has just been filled |
| resp_way | output | $clog2(WAYS) | Way that hit or was filled |
| fill_valid | output | 1 | Line request to backing memory |
| fill_addr | output | ADDR_W | Line address being fetched |
| fill_ready | input | 1 | Backing memory delivers the line this cycle |

## Verification
Two rules meet in one victim decision: empty-way priority and the discard-flag preference. The bench provokes this by filling three ways of a set, one of them with the hint set, and then missing again. The reported `resp_way` must be the empty way, not the flagged one. A second point of contact is the cycle in which a fill completes. That cycle carries the response, the tag install, the flag write and the ageing of the whole set. The bench judges it by the victims of later misses, which depend on all of those writes being applied together.

// File: rtl/ehc_pkg.sv
package ehc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FILL   = 2'd2
    } ehc_state_e;

endpackage

// File: rtl/ehc_line_store.sv
module ehc_line_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    parameter int IDX_W = 4,
    parameter int WAY_W = 2,
    parameter int AGE_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            set_idx,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0]             rd_vld,
    output logic [WAYS-1:0]             rd_evm,
    output logic [WAYS-1:0][AGE_W-1:0]  rd_age,
    input  logic                        wr_en,
    input  logic                        wr_install,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic                        wr_hint,
    input  logic [WAYS-1:0][AGE_W-1:0]  wr_age
);

    logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
    logic [WAYS-1:0]            vld_q [SETS];
    logic [WAYS-1:0]            evm_q [SETS];
    logic [WAYS-1:0][AGE_W-1:0] age_q [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                evm_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    age_q[s][w] <= AGE_W'(w);
                end
            end
        end else if (wr_en) begin
            age_q[set_idx]         <= wr_age;
            evm_q[set_idx][wr_way] <= wr_hint;
            if (wr_install) begin
                tag_q[set_idx][wr_way] <= wr_tag;
                vld_q[set_idx][wr_way] <= 1'b1;
            end
        end
    end

    assign rd_tag = tag_q[set_idx];
    assign rd_vld = vld_q[set_idx];
    assign rd_evm = evm_q[set_idx];
    assign rd_age = age_q[set_idx];

endmodule

// File: rtl/ehc_victim_pick.sv
module ehc_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2,
    parameter int AGE_W = 2
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0]            evm,
    input  logic [WAYS-1:0][AGE_W-1:0] age,
    output logic [WAY_W-1:0]           victim
);

    logic             inv_found;
    logic [WAY_W-1:0] inv_way;
    logic             flg_found;
    logic [WAY_W-1:0] flg_way;
    logic [AGE_W-1:0] flg_age;
    logic [WAY_W-1:0] old_way;
    logic [AGE_W-1:0] old_age;

    // lowest-numbered empty way
    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
        end
    end

    // oldest flagged valid way
    always_comb begin
        flg_found = 1'b0;
        flg_way   = '0;
        flg_age   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld[w] && evm[w] && (!flg_found || age[w] > flg_age)) begin
                flg_found = 1'b1;
                flg_way   = WAY_W'(w);
                flg_age   = age[w];
            end
        end
    end

    // oldest way overall
    always_comb begin
        old_way = '0;
        old_age = age[0];
        for (int w = 1; w < WAYS; w++) begin
            if (age[w] > old_age) begin
                old_way = WAY_W'(w);
                old_age = age[w];
            end
        end
    end

    always_comb begin
        if (inv_found)      victim = inv_way;
        else if (flg_found) victim = flg_way;
        else                victim = old_way;
    end

endmodule

// File: rtl/ehc_age_update.sv
module ehc_age_update #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2,
    parameter int AGE_W = 2
) (
    input  logic [WAYS-1:0][AGE_W-1:0] age_in,
    input  logic [WAY_W-1:0]           touch_way,
    output logic [WAYS-1:0][AGE_W-1:0] age_out
);

    logic [AGE_W-1:0] touched_age;

    assign touched_age = age_in[touch_way];

    for (genvar w = 0; w < WAYS; w++) begin : g_age
        always_comb begin
            if (WAY_W'(w) == touch_way)
                age_out[w] = '0;
            else if (age_in[w] < touched_age)
                age_out[w] = age_in[w] + AGE_W'(1);
            else
                age_out[w] = age_in[w];
        end
    end

endmodule

// File: rtl/evict_hint_cache.sv
module evict_hint_cache
    import ehc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W,
    localparam int WAY_W = $clog2(WAYS),
    localparam int AGE_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_hint,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WAY_W-1:0]  resp_way,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_ready
);

    ehc_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic              hint_q;
    logic [WAY_W-1:0]  victim_q;

    logic [IDX_W-1:0] cur_idx;
    logic [TAG_W-1:0] cur_tag;

    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0]            rd_vld;
    logic [WAYS-1:0]            rd_evm;
    logic [WAYS-1:0][AGE_W-1:0] rd_age;
    logic [WAYS-1:0][AGE_W-1:0] nxt_age;

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim_way;

    logic             wr_en;
    logic             wr_install;
    logic [WAY_W-1:0] wr_way;

    assign cur_idx = addr_q[IDX_W-1:0];
    assign cur_tag = addr_q[ADDR_W-1:IDX_W];

    ehc_line_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W),
        .IDX_W(IDX_W), .WAY_W(WAY_W), .AGE_W(AGE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_idx   (cur_idx),
        .rd_tag    (rd_tag),
        .rd_vld    (rd_vld),
        .rd_evm    (rd_evm),
        .rd_age    (rd_age),
        .wr_en     (wr_en),
        .wr_install(wr_install),
        .wr_way    (wr_way),
        .wr_tag    (cur_tag),
        .wr_hint   (hint_q),
        .wr_age    (nxt_age)
    );

    ehc_victim_pick #(
        .WAYS(WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)
    ) u_pick (
        .vld   (rd_vld),
        .evm   (rd_evm),
        .age   (rd_age),
        .victim(victim_way)
    );

    ehc_age_update #(
        .WAYS(WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)
    ) u_age (
        .age_in   (rd_age),
        .touch_way(wr_way),
        .age_out  (nxt_age)
    );

    // tag compare across the addressed set
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rd_vld[w] && rd_tag[w] == cur_tag) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    // state register and request/victim capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            hint_q   <= 1'b0;
            victim_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                addr_q <= req_addr;
                hint_q <= req_hint;
            end
            if (state_q == ST_LOOKUP && !hit)
                victim_q <= victim_way;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)  state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = hit ? ST_IDLE : ST_FILL;
            ST_FILL:   if (fill_ready) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and store write strobes
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        resp_hit   = 1'b0;
        resp_way   = victim_q;
        fill_valid = 1'b0;
        fill_addr  = addr_q;
        wr_en      = 1'b0;
        wr_install = 1'b0;
        wr_way     = victim_q;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_LOOKUP: begin
                if (hit) begin
                    resp_valid = 1'b1;
                    resp_hit   = 1'b1;
                    resp_way   = hit_way;
                    wr_en      = 1'b1;
                    wr_way     = hit_way;
                end
            end
            ST_FILL: begin
                fill_valid = 1'b1;
                if (fill_ready) begin
                    resp_valid = 1'b1;
                    wr_en      = 1'b1;
                    wr_install = 1'b1;
                end
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/evict_hint_cache_chk.sv
module evict_hint_cache_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              fill_ready
);

    p_hit_next_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> $past(req_valid && req_ready));

    p_fill_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_addr)));

    p_fill_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_valid) |-> (fill_addr == $past(req_addr, 2)));

    p_miss_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (fill_valid && fill_ready));

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_no_accept_in_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

endmodule

bind evict_hint_cache evict_hint_cache_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .resp_valid(resp_valid),
    .resp_hit  (resp_hit),
    .fill_valid(fill_valid),
    .fill_addr (fill_addr),
    .fill_ready(fill_ready)
);

// File: tb/evict_hint_cache_tb_top.sv
module evict_hint_cache_tb_top;

    localparam int ADDR_W   = 12;
    localparam int SETS     = 16;
    localparam int WAYS     = 4;
    localparam int WAY_W    = $clog2(WAYS);
    localparam int FILL_LAT = 3;
    localparam int NVEC     = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_hint = 1'b0;
    logic              resp_valid;
    logic              resp_hit;
    logic [WAY_W-1:0]  resp_way;
    logic              fill_valid;
    logic [ADDR_W-1:0] fill_addr;
    logic              fill_ready;

    int compared = 0;
    int mismatched = 0;
    int lat_cnt;

    always #10 clk = ~clk;

    evict_hint_cache #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_hint(req_hint),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_ready(fill_ready)
    );

    // backing memory: fixed latency
    always @(posedge clk) begin
        if (!rst_n) begin
            fill_ready <= 1'b0;
            lat_cnt    <= 0;
        end else if (fill_ready) begin
            fill_ready <= 1'b0;
            lat_cnt    <= 0;
        end else if (fill_valid) begin
            if (lat_cnt == FILL_LAT - 1) fill_ready <= 1'b1;
            else                         lat_cnt <= lat_cnt + 1;
        end
    end

    // {addr, hint, exp_hit, exp_way}; set 0 unless noted
    localparam logic [15:0] VEC [NVEC] = '{
        {12'h010, 1'b0, 1'b0, 2'd0},   // R4 empty way 0
        {12'h020, 1'b1, 1'b0, 2'd1},   // R8 fill flagged
        {12'h030, 1'b0, 1'b0, 2'd2},
        {12'h040, 1'b0, 1'b0, 2'd3},   // R4 empty beats flagged way 1
        {12'h050, 1'b0, 1'b0, 2'd1},   // R5 flagged beats LRU way 0
        {12'h060, 1'b0, 1'b0, 2'd0},   // R6 plain LRU
        {12'h030, 1'b1, 1'b1, 2'd2},   // R2/R7 hit sets flag
        {12'h050, 1'b1, 1'b1, 2'd1},   // R7
        {12'h070, 1'b0, 1'b0, 2'd2},   // R5 oldest of flagged ways
        {12'h050, 1'b0, 1'b1, 2'd1},   // R7 hit clears flag
        {12'h080, 1'b1, 1'b0, 2'd3},   // R6
        {12'h090, 1'b0, 1'b0, 2'd3},   // R8 flagged fill evicted
        {12'h080, 1'b0, 1'b0, 2'd0},   // R6
        {12'h090, 1'b0, 1'b1, 2'd3},
        {12'h015, 1'b1, 1'b0, 2'd0},   // R9 set 5 fresh
        {12'h015, 1'b0, 1'b1, 2'd0},
        {12'h070, 1'b0, 1'b1, 2'd2},   // R9 set 0 untouched
        {12'h050, 1'b0, 1'b1, 2'd1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input logic h,
                          output logic got_hit, output logic [WAY_W-1:0] got_way);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_hint  = h;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10 busy", int'(req_ready), 0);
        if (!resp_valid) begin
            @(negedge clk);
            for (int i = 0; i < 20 && !resp_valid; i++) begin
                check(fill_valid && fill_addr == a, "R3 fill_addr", int'(fill_addr), int'(a));
                @(negedge clk);
            end
        end
        check(resp_valid == 1'b1, "R2/R3 resp_valid", int'(resp_valid), 1);
        got_hit = resp_hit;
        got_way = resp_way;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic             h;
        logic [WAY_W-1:0] w;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
        check(resp_valid == 1'b0, "R1 resp_valid", int'(resp_valid), 0);
        check(fill_valid == 1'b0, "R1 fill_valid", int'(fill_valid), 0);

        for (int v = 0; v < NVEC; v++) begin
            access(VEC[v][15:4], VEC[v][3], h, w);
            check({h, w} == VEC[v][2:0], $sformatf("vector %0d hit/way R2-R9", v),
                  int'({h, w}), int'(VEC[v][2:0]));
        end

        // R10: ready back after response
        @(negedge clk);
        check(req_ready == 1'b1, "R10 ready restored", int'(req_ready), 1);

        // R1: later reset invalidates everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(12'h050, 1'b0, h, w);
        check(h == 1'b0 && w == '0, "R1 miss after reset", int'({h, w}), 0);
        access(12'h050, 1'b0, h, w);
        check(h == 1'b1 && w == '0, "R2 hit after refill", int'({h, w}), 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule